// File: doc/BRIEF.md
# Programmable PIO Bus Cycle Timer

This block is the host-side engine for programmed-I/O word transfers to an ATA-style storage device. A single request (direction, 4-bit register address, 16-bit write word) is accepted while the block reports itself idle. The block then runs one bus cycle: it drives the chip selects and 3-bit register address for a setup interval, asserts the active-low read or write strobe, and finally releases the strobe and waits out a recovery interval before it returns to idle and pulses `done_o`. On reads, the data word present on the device bus at the last clock of the strobe is returned on `rdata_o`.

The timing mode (0 to 4) is picked per request. The setup, strobe and recovery clock counts are computed from the mode's nanosecond figures and the clock period. Each count is rounded up, and recovery takes the remainder of the cycle, so the whole cycle is never shorter than the mode's minimum: 600, 383, 240, 180 and 120 ns. In the two fastest modes, a low level on the device-ready input stretches the strobe. A stretch that lasts too long ends the cycle and raises an error flag.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, both chip selects and both strobes are high, `dd_oe_o` is 0, `done_o` and `timeout_err_o` are 0, and `ready_o` is 1.
- R2: A request is taken only while `ready_o` is 1. `req_valid_i` while busy has no effect on the running cycle and starts no later cycle.
- R3: After acceptance, the chip select and `da_o` are active for exactly S = ceil(setup_ns / clock period) clocks before the strobe falls. setup_ns is 70, 50, 30, 30 and 25 for modes 0 to 4.
- R4: In modes 0 to 2 the strobe stays low for exactly A = ceil(active_ns / period) clocks, whatever `iordy_i` does. active_ns is 165, 125, 100, 80 and 70.
- R5: The chip select and address stay valid through recovery. The cycle lasts C = ceil(cycle_ns / period) clocks in total, so C times the period is at least the mode's minimum cycle time.
- R6: In modes 3 and 4, `iordy_i` passes through a 2-flop synchronizer. If it rises in strobe clock h (counted from 0) after being low, the strobe width is max(A, h+3).
- R7: In modes 3 and 4, if `iordy_i` stays low, the strobe ends after A+1024 clocks and `timeout_err_o` is set. The flag stays set until the next request is accepted.
- R8: A write drives `dd_o` with the request word and sets `dd_oe_o` for the whole cycle. `diow_n_o` is the strobe; `dior_n_o` stays high.
- R9: A read uses `dior_n_o` and returns on `rdata_o` the `dd_i` value present in the last strobe-low clock. `done_o` is high for exactly one clock, the first idle clock after recovery.
- R10: Address bit 3 picks the chip select (0 gives `cs0_n_o`, 1 gives `cs1_n_o`). Bits 2:0 appear on `da_o`.
- R11: Mode values 5 to 7 run with mode 4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Timing mode for the request |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | {chip-select pick, register address} |
| req_wdata_i | input | 16 | Write word |
| ready_o | output | 1 | Idle, request may be given |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | 16 | Captured read word |
| timeout_err_o | output | 1 | Last cycle ended by ready timeout |
| cs0_n_o | output | 1 | Chip select 0, active low |
| cs1_n_o | output | 1 | Chip select 1, active low |
| da_o | output | 3 | Device register address |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Data bus out |
| dd_oe_o | output | 1 | Data bus drive enable |
| dd_i | input | 16 | Data bus in |
| iordy_i | input | 1 | Device ready |

## Verification
The bench runs each mode with reads and writes and compares every pin on every clock against a behavioural model, so a setup, strobe or recovery count that is off by one clock shows up. Ready is exercised in four ways: held high, held low in a slow mode (where it must be ignored), released late (a stretch whose length separates the synchronizer depth from the base count), and never released (timeout). Further runs tell the two chip selects apart, feed a request to a busy block, use a clamped mode value, and change `dd_i` right after the strobe rises to confirm at which edge read data is captured.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int CNT_W  = 8;
  localparam int NMODES = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOVER} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recover;
  } phase_cnt_t;

  // Address-to-strobe lead per mode, in ns
  function automatic int lead_ns(input int m);
    case (m)
      0: return 70;
      1: return 50;
      2: return 30;
      3: return 30;
      default: return 25;
    endcase
  endfunction

  // Strobe low time per mode, in ns
  function automatic int pulse_ns(input int m);
    case (m)
      0: return 165;
      1: return 125;
      2: return 100;
      3: return 80;
      default: return 70;
    endcase
  endfunction

  // Minimum whole-cycle time per mode, in ns
  function automatic int period_ns(input int m);
    case (m)
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      default: return 120;
    endcase
  endfunction

  function automatic int ceil_clocks(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic phase_cnt_t mode_counts(input int m, input int clk_ps);
    int s, a, c, r;
    phase_cnt_t res;
    s = ceil_clocks(lead_ns(m), clk_ps);
    a = ceil_clocks(pulse_ns(m), clk_ps);
    c = ceil_clocks(period_ns(m), clk_ps);
    if (s < 1) s = 1;
    if (a < 1) a = 1;
    r = c - s - a;
    if (r < 1) r = 1;
    res.setup   = CNT_W'(s);
    res.active  = CNT_W'(a);
    res.recover = CNT_W'(r);
    return res;
  endfunction

endpackage

// File: rtl/pio_mode_table.sv
module pio_mode_table
  import pio_timer_pkg::*;
#(
  parameter int CLK_PS = 5000
) (
  input  logic [2:0] mode_i,
  output phase_cnt_t counts_o
);
  localparam int LAST = NMODES - 1;

  phase_cnt_t table_q [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_entry
    assign table_q[m] = mode_counts(m, CLK_PS);
  end

  logic [2:0] sel;
  always_comb begin
    sel = (int'(mode_i) > LAST) ? 3'(LAST) : mode_i;
    counts_o = table_q[sel];
  end
endmodule

// File: rtl/pio_ready_sync.sv
module pio_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_timer_pkg::*;
#(
  parameter int TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       use_ready_i,
  input  logic       dev_ready_i,
  input  phase_cnt_t counts_i,
  output phase_e     phase_o,
  output logic       capture_o,
  output logic       finish_o,
  output logic       timeout_o
);
  localparam int EXT_W = $clog2(TIMEOUT + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] ext_q;

  logic base_end, stall, active_end, recover_end;

  always_comb begin
    base_end    = (phase_q == PH_ACTIVE) && (cnt_q == '0);
    stall       = base_end && use_ready_i && !dev_ready_i && (ext_q != EXT_W'(TIMEOUT));
    active_end  = base_end && !stall;
    recover_end = (phase_q == PH_RECOVER) && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ext_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= counts_i.setup - 1'b1;
        end
        PH_SETUP: if (cnt_q == '0) begin
          phase_q <= PH_ACTIVE;
          cnt_q   <= counts_i.active - 1'b1;
          ext_q   <= '0;
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACTIVE: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (stall) ext_q <= ext_q + 1'b1;
          else begin
            phase_q <= PH_RECOVER;
            cnt_q   <= counts_i.recover - 1'b1;
          end
        default: if (recover_end) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign capture_o = active_end;
  assign finish_o  = recover_end;
  assign timeout_o = active_end && use_ready_i && !dev_ready_i;

  // R7
  ext_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE && ext_q == EXT_W'(TIMEOUT)) |=> (phase_q == PH_RECOVER));
  // R4
  no_stall_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_end && !use_ready_i) |=> (phase_q == PH_RECOVER));
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int TIMEOUT     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode_i,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [3:0]  req_addr_i,
  input  logic [15:0] req_wdata_i,
  output logic        ready_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        timeout_err_o,
  output logic        cs0_n_o,
  output logic        cs1_n_o,
  output logic [2:0]  da_o,
  output logic        dior_n_o,
  output logic        diow_n_o,
  output logic [15:0] dd_o,
  output logic        dd_oe_o,
  input  logic [15:0] dd_i,
  input  logic        iordy_i
);
  localparam int READY_MODE = 3;

  phase_e     phase;
  phase_cnt_t counts;
  logic [2:0] mode_q, tbl_mode;
  logic       wr_q;
  logic [3:0] addr_q;
  logic [15:0] wdata_q;
  logic       accept, use_ready, dev_ready;
  logic       capture, finish, timeout_hit;
  logic       cycle_live, strobe_on;

  assign accept    = req_valid_i && (phase == PH_IDLE);
  assign tbl_mode  = (phase == PH_IDLE) ? mode_i : mode_q;
  assign use_ready = (int'(mode_q) >= READY_MODE);

  pio_mode_table #(.CLK_PS(CLK_PS)) u_table (
    .mode_i   (tbl_mode),
    .counts_o (counts)
  );

  pio_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (iordy_i),
    .sync_o  (dev_ready)
  );

  pio_phase_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .use_ready_i (use_ready),
    .dev_ready_i (dev_ready),
    .counts_i    (counts),
    .phase_o     (phase),
    .capture_o   (capture),
    .finish_o    (finish),
    .timeout_o   (timeout_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= '0;
      wr_q          <= 1'b0;
      addr_q        <= '0;
      wdata_q       <= '0;
      rdata_o       <= '0;
      done_o        <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (accept) begin
        mode_q        <= mode_i;
        wr_q          <= req_write_i;
        addr_q        <= req_addr_i;
        wdata_q       <= req_wdata_i;
        timeout_err_o <= 1'b0;
      end else if (timeout_hit) begin
        timeout_err_o <= 1'b1;
      end
      if (capture && !wr_q) rdata_o <= dd_i;
    end
  end

  assign cycle_live = (phase != PH_IDLE);
  assign ready_o    = !cycle_live;
  assign cs0_n_o    = !(cycle_live && !addr_q[3]);
  assign cs1_n_o    = !(cycle_live && addr_q[3]);
  assign da_o       = addr_q[2:0];
  assign dior_n_o   = !(phase == PH_ACTIVE && !wr_q);
  assign diow_n_o   = !(phase == PH_ACTIVE && wr_q);
  assign dd_o       = wdata_q;
  assign dd_oe_o    = cycle_live && wr_q;
  assign strobe_on  = !dior_n_o || !diow_n_o;

  // R3
  cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $past(!cs0_n_o || !cs1_n_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> $stable(addr_q) && $stable(wr_q));
  // R8
  oe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe_o |-> !ready_o);
  // R7
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> $past(strobe_on) && $past(use_ready));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~dior_n_o, ~diow_n_o}));
endmodule

// File: tb/pio_cycle_timer_tb.sv
module pio_cycle_timer_tb;
  localparam int PER_PS = 5000;
  localparam int TMO    = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode;
  logic req_valid, req_write, iordy;
  logic [3:0] req_addr;
  logic [15:0] req_wdata, dd_i;
  logic ready, done, err, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_o;
  logic [2:0] da;

  int checks = 0, failures = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pio_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .timeout_err_o(err),
    .cs0_n_o(cs0_n), .cs1_n_o(cs1_n), .da_o(da), .dior_n_o(dior_n),
    .diow_n_o(diow_n), .dd_o(dd_o), .dd_oe_o(dd_oe), .dd_i(dd_i), .iordy_i(iordy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clocks_for(input int ns);
    int c = 0;
    while (c * PER_PS < ns * 1000) c++;
    return c;
  endfunction

  function automatic int t_lead(input int m);
    int lead [5] = '{70, 50, 30, 30, 25};
    return lead[m];
  endfunction
  function automatic int t_pulse(input int m);
    int p [5] = '{165, 125, 100, 80, 70};
    return p[m];
  endfunction
  function automatic int t_cyc(input int m);
    int c [5] = '{600, 383, 240, 180, 120};
    return c[m];
  endfunction

  // h >= 0: iordy rises in strobe clock h; -1: always high; -2: never high
  task automatic xfer(input int m_in, input bit wr, input logic [3:0] addr,
                      input logic [15:0] wd, input logic [15:0] rv,
                      input int h, input bit poke_busy);
    int m, S, A, W, C, R, lo_cnt, cs_cnt, bad;
    bit slow, in_cyc, stb;
    logic [6:0] act_v, exp_v;
    m = (m_in > 4) ? 4 : m_in;
    slow = (m >= 3);
    S = clocks_for(t_lead(m));
    A = clocks_for(t_pulse(m));
    C = clocks_for(t_cyc(m));
    R = C - S - A;
    if (!slow || h == -1) W = A;
    else if (h == -2) W = A + TMO;
    else W = (A > h + 3) ? A : h + 3;
    @(negedge clk);
    mode = 3'(m_in); req_write = wr; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1; iordy = (h == -1); dd_i = rv;
    lo_cnt = 0; cs_cnt = 0; bad = 0;
    for (int t = 0; t <= S + W + R; t++) begin
      @(negedge clk);
      if (t == 0) begin req_valid = 1'b0; mode = 3'd0; end
      in_cyc = (t < S + W + R);
      stb = (t >= S) && (t < S + W);
      exp_v = {!(in_cyc && !addr[3]), !(in_cyc && addr[3]), !(stb && !wr),
               !(stb && wr), in_cyc && wr, !in_cyc, t == S + W + R};
      act_v = {cs0_n, cs1_n, dior_n, diow_n, dd_oe, ready, done};
      if (act_v != exp_v) begin
        bad++;
        $display("FAIL R5 pin shape mode=%0d t=%0d actual=%b expected=%b", m_in, t, act_v, exp_v);
      end
      if (in_cyc && (da != addr[2:0] || (wr && dd_o != wd))) begin
        bad++;
        $display("FAIL R10 addr/data t=%0d actual=%0h/%0h expected=%0h/%0h", t, da, dd_o, addr[2:0], wd);
      end
      if (!dior_n || !diow_n) lo_cnt++;
      if (!cs0_n || !cs1_n) cs_cnt++;
      if (h >= 0 && stb && t - S == h) iordy = 1'b1;
      if (t == S + W) dd_i = ~rv;
      if (poke_busy && t == 2) begin req_valid = 1'b1; req_addr = addr ^ 4'h9; end
      if (poke_busy && t == 3) req_valid = 1'b0;
    end
    check(bad == 0, "R3 R4 R5 R8 R10 per-clock compare", bad, 0);
    if (slow && h >= 0) check(lo_cnt == W, "R6 stretched strobe width", lo_cnt, W);
    else if (h == -2 && slow) check(lo_cnt == W, "R7 timeout strobe width", lo_cnt, W);
    else check(lo_cnt == W, "R4 strobe width", lo_cnt, W);
    check(cs_cnt == S + W + R && (S + A + R) * PER_PS >= t_cyc(m) * 1000,
          "R5 cycle length", cs_cnt, S + W + R);
    if (!wr) check(rdata == rv, "R9 read capture", rdata, rv);
    check(err == (slow && h == -2), "R7 error flag", err, slow && h == -2);
    @(negedge clk);
    check(!done && ready && cs0_n && cs1_n, "R2 R9 idle after cycle",
          {done, ready, cs0_n, cs1_n}, 4'b0111);
    if (m_in > 4) check(S == 5 && A == 14, "R11 clamped mode", A, 14);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    mode = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    dd_i = 0; iordy = 1;
    repeat (3) @(negedge clk);
    check(ready && cs0_n && cs1_n && dior_n && diow_n && !dd_oe && !done && !err,
          "R1 reset state", {ready, cs0_n, cs1_n, dior_n, diow_n, dd_oe, done, err}, 8'hF8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(0, 1'b0, 4'h0, 16'h0000, 16'hA55A, -1, 1'b0);
    xfer(1, 1'b1, 4'h2, 16'h1234, 16'h0000, -1, 1'b0);
    xfer(2, 1'b0, 4'h7, 16'h0000, 16'h0F0F, -2, 1'b0);
    xfer(3, 1'b0, 4'h3, 16'h0000, 16'hBEEF, -1, 1'b0);
    xfer(3, 1'b0, 4'h5, 16'h0000, 16'hC001, 30, 1'b0);
    xfer(4, 1'b1, 4'h6, 16'h8001, 16'h0000, 5, 1'b0);
    xfer(4, 1'b0, 4'h1, 16'h0000, 16'h5AA5, -2, 1'b0);
    xfer(2, 1'b1, 4'h4, 16'hFACE, 16'h0000, -1, 1'b1);
    xfer(6, 1'b0, 4'hE, 16'h0000, 16'h7E57, -1, 1'b0);
    xfer(0, 1'b1, 4'hF, 16'hFFFF, 16'h0000, -2, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule